// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits beside the decode stage of a five-stage in-order pipeline. It looks at the instruction now in execute. If that instruction is a load whose destination register is named as a source by the instruction in decode, the loaded value cannot reach execute in time, even with forwarding. In that case the block holds the program counter and the fetch/decode pipeline register for one cycle. It also zeroes the control fields written into the decode/execute register, so a no-op bubble goes down the pipe in place of the dependent instruction.

The dependent instruction is therefore decoded a second time one cycle later. By then the load has moved into the memory/writeback stage, and the normal forwarding path can supply the value. The detection is purely combinational: it has to act in the same cycle in which the instruction pair is present. The pipeline registers that feed it belong to the surrounding datapath.

Top module: `ldu_stall_unit`

## Requirements
- R1: When `ex_mem_read` is 1, `ex_dst_reg` is non-zero and `ex_dst_reg` equals `dec_src_a`, the outputs in that same cycle are `pc_wr_en`=0, `fd_wr_en`=0 and `de_bubble`=1.
- R2: When `ex_mem_read` is 1, `ex_dst_reg` is non-zero and `ex_dst_reg` equals `dec_src_b`, the outputs are `pc_wr_en`=0, `fd_wr_en`=0 and `de_bubble`=1.
- R3: When `ex_mem_read` is 0, no stall is requested, whatever the register numbers are.
- R4: A load whose destination is register 0 never requests a stall, even when a decode source is also 0.
- R5: Without a hazard, `pc_wr_en`=1, `fd_wr_en`=1 and `de_bubble`=0 (all enables are active-high).
- R6: The three outputs always agree: `pc_wr_en` equals `fd_wr_en`, and `de_bubble` is their inverse.
- R7: In a pipeline that reloads the decode/execute register with zero control while `de_bubble`=1, one load followed by a dependent instruction stalls for exactly one cycle. The dependent instruction is then held in decode for two cycles, and no two consecutive cycles stall.
- R8: Across a code sequence, the total number of stall cycles equals the number of load-use adjacencies: a sequence with two adjacent load-use pairs gives 2 stalls, and the same work reordered so that no loaded register is used by the next instruction gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_mem_read | input | 1 | Memory-read control bit held in the decode/execute register |
| ex_dst_reg | input | REG_W | Destination register number of the instruction in execute |
| dec_src_a | input | REG_W | First source register number from the fetch/decode register |
| dec_src_b | input | REG_W | Second source register number from the fetch/decode register |
| pc_wr_en | output | 1 | Program counter update enable, 0 during a stall |
| fd_wr_en | output | 1 | Fetch/decode register write enable, 0 during a stall |
| de_bubble | output | 1 | Forces zero control into the decode/execute register |

## Verification
The comparator is driven with a match on the first source only, a match on the second source only, and matches on both. These show that each source path is checked on its own. The same matches are then repeated with the memory-read flag clear and with destination register 0. This shows that each qualifier by itself suppresses the stall, and that any remaining mismatch case leaves the enables high. Last, a small pipeline model runs one sequence with two load-use pairs and a reordered version of the same work. Comparing the stall counts and the number of cycles the dependent instruction spends in decode separates a one-cycle stall from a missing stall or a repeated one.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  // Number of source operands compared against the load destination.
  localparam int NSRC = 2;

  typedef struct packed {
    logic pc_we;
    logic fd_we;
    logic bubble;
  } stall_ctl_t;
endpackage

// File: rtl/ldu_reg_match.sv
module ldu_reg_match #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [REG_W-1:0]      dst_reg,
  input  logic [NSRC*REG_W-1:0] src_regs,
  output logic [NSRC-1:0]       hit
);
  logic dst_live;
  assign dst_live = |dst_reg;  // register 0 is hard-wired, never a true producer

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign hit[g] = dst_live && (src_regs[g*REG_W +: REG_W] == dst_reg);
  end
endmodule

// File: rtl/ldu_hazard_detect.sv
module ldu_hazard_detect #(
  parameter int NSRC = 2
) (
  input  logic            mem_read,
  input  logic [NSRC-1:0] hit,
  output logic            hazard
);
  assign hazard = mem_read && (|hit);
endmodule

// File: rtl/ldu_ctl_drive.sv
module ldu_ctl_drive
  import ldu_pkg::*;
(
  input  logic       hazard,
  output stall_ctl_t ctl
);
  always_comb begin
    ctl.pc_we  = 1'b1;
    ctl.fd_we  = 1'b1;
    ctl.bubble = 1'b0;
    if (hazard) begin
      ctl.pc_we  = 1'b0;
      ctl.fd_we  = 1'b0;
      ctl.bubble = 1'b1;
    end
  end
endmodule

// File: rtl/ldu_stall_unit.sv
module ldu_stall_unit
  import ldu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             ex_mem_read,
  input  logic [REG_W-1:0] ex_dst_reg,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  output logic             pc_wr_en,
  output logic             fd_wr_en,
  output logic             de_bubble
);
  localparam int SRC_BITS = NSRC * REG_W;

  logic [SRC_BITS-1:0] src_vec;
  logic [NSRC-1:0]     hit;
  logic                hazard;
  stall_ctl_t          ctl;

  assign src_vec = {dec_src_b, dec_src_a};

  ldu_reg_match #(.REG_W(REG_W), .NSRC(NSRC)) u_match (
    .dst_reg  (ex_dst_reg),
    .src_regs (src_vec),
    .hit      (hit)
  );

  ldu_hazard_detect #(.NSRC(NSRC)) u_detect (
    .mem_read (ex_mem_read),
    .hit      (hit),
    .hazard   (hazard)
  );

  ldu_ctl_drive u_drive (
    .hazard (hazard),
    .ctl    (ctl)
  );

  assign pc_wr_en  = ctl.pc_we;
  assign fd_wr_en  = ctl.fd_we;
  assign de_bubble = ctl.bubble;
endmodule

// File: rtl/ldu_stall_chk.sv
module ldu_stall_chk #(
  parameter int REG_W = 5
) (
  input logic             ex_mem_read,
  input logic [REG_W-1:0] ex_dst_reg,
  input logic [REG_W-1:0] dec_src_a,
  input logic [REG_W-1:0] dec_src_b,
  input logic             pc_wr_en,
  input logic             fd_wr_en,
  input logic             de_bubble
);
  logic known;
  assign known = !$isunknown({ex_mem_read, ex_dst_reg, dec_src_a, dec_src_b,
                              pc_wr_en, fd_wr_en, de_bubble});

  always_comb begin
    if (known) begin
      if (ex_mem_read && ex_dst_reg != '0 && ex_dst_reg == dec_src_a)
        a_r1_src_a_stalls: assert (de_bubble && !pc_wr_en && !fd_wr_en);
      if (ex_mem_read && ex_dst_reg != '0 && ex_dst_reg == dec_src_b)
        a_r2_src_b_stalls: assert (de_bubble && !pc_wr_en && !fd_wr_en);
      if (!ex_mem_read)
        a_r3_no_read_no_stall: assert (!de_bubble);
      if (ex_dst_reg == '0)
        a_r4_zero_dst_no_stall: assert (!de_bubble);
      if (!de_bubble)
        a_r5_idle_enables_high: assert (pc_wr_en && fd_wr_en);
      a_r6_outputs_agree: assert (pc_wr_en == fd_wr_en && de_bubble == !pc_wr_en);
    end
  end
endmodule

bind ldu_stall_unit ldu_stall_chk #(.REG_W(REG_W)) u_chk (
  .ex_mem_read (ex_mem_read),
  .ex_dst_reg  (ex_dst_reg),
  .dec_src_a   (dec_src_a),
  .dec_src_b   (dec_src_b),
  .pc_wr_en    (pc_wr_en),
  .fd_wr_en    (fd_wr_en),
  .de_bubble   (de_bubble)
);

// File: tb/sim_ldu_stall_unit.sv
module sim_ldu_stall_unit;
  localparam int RW = 5;

  typedef struct packed {
    logic          ld;
    logic [RW-1:0] dst;
    logic [RW-1:0] s1;
    logic [RW-1:0] s2;
  } ins_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  int n_vec = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  // direct stimulus / pipeline model select
  logic          pipe_mode = 1'b0;
  logic          d_mr = 1'b0;
  logic [RW-1:0] d_dst = '0, d_a = '0, d_b = '0;

  logic          mr, pc_we, fd_we, bub;
  logic [RW-1:0] dst, sa, sb;

  // small pipeline model: PC, fetch/decode and decode/execute registers
  ins_t rom [16];
  int   pc;
  ins_t ifid;
  int   ifid_tag;
  logic idex_mr;
  logic [RW-1:0] idex_dst;
  int   stalls, run_len, max_run, dec2_cnt, dec5_cnt;

  always_comb begin
    if (pipe_mode) begin
      mr = idex_mr; dst = idex_dst; sa = ifid.s1; sb = ifid.s2;
    end else begin
      mr = d_mr; dst = d_dst; sa = d_a; sb = d_b;
    end
  end

  ldu_stall_unit #(.REG_W(RW)) u0 (
    .ex_mem_read (mr),
    .ex_dst_reg  (dst),
    .dec_src_a   (sa),
    .dec_src_b   (sb),
    .pc_wr_en    (pc_we),
    .fd_wr_en    (fd_we),
    .de_bubble   (bub)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= 0; ifid <= '0; ifid_tag <= -1;
      idex_mr <= 1'b0; idex_dst <= '0;
      stalls <= 0; run_len <= 0; max_run <= 0; dec2_cnt <= 0; dec5_cnt <= 0;
    end else if (pipe_mode) begin
      if (pc_we) pc <= pc + 1;
      if (fd_we) begin
        ifid     <= (pc < 16) ? rom[pc] : '0;
        ifid_tag <= pc;
      end
      if (bub) begin
        idex_mr <= 1'b0; idex_dst <= '0;
      end else begin
        idex_mr <= ifid.ld; idex_dst <= ifid.dst;
      end
      if (bub) begin
        stalls  <= stalls + 1;
        run_len <= run_len + 1;
        if (run_len + 1 > max_run) max_run <= run_len + 1;
      end else run_len <= 0;
      if (ifid_tag == 2) dec2_cnt <= dec2_cnt + 1;
      if (ifid_tag == 5) dec5_cnt <= dec5_cnt + 1;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic probe(input string req, input logic m, input int t, input int a, input int b);
    logic exp_stall;
    d_mr = m; d_dst = RW'(t); d_a = RW'(a); d_b = RW'(b);
    #1;
    exp_stall = m && (t != 0) && (t == a || t == b);
    check({pc_we, fd_we, bub} == {!exp_stall, !exp_stall, exp_stall}, req,
          int'({pc_we, fd_we, bub}), int'({!exp_stall, !exp_stall, exp_stall}));
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    pipe_mode = 1'b1;
    #0;
    check(pc_we && fd_we && !bub, "R5 reset", int'({pc_we, fd_we, bub}), 6);
    pipe_mode = 1'b0;
  endtask

  task automatic t_src_a;  probe("R1", 1, 9, 9, 3);   probe("R1", 1, 31, 31, 0); endtask
  task automatic t_src_b;  probe("R2", 1, 10, 4, 10); probe("R2", 1, 7, 7, 7);   endtask
  task automatic t_no_read;
    probe("R3", 0, 9, 9, 3); probe("R3", 0, 12, 1, 12); probe("R3", 0, 5, 5, 5);
  endtask
  task automatic t_zero_dst; probe("R4", 1, 0, 0, 0); probe("R4", 1, 0, 0, 6); endtask
  task automatic t_idle;
    probe("R5", 1, 9, 8, 10); probe("R5", 0, 0, 1, 2); probe("R6", 1, 1, 2, 3);
  endtask

  function automatic ins_t mk(input logic ld, input int d, input int a, input int b);
    ins_t r;
    r.ld = ld; r.dst = RW'(d); r.s1 = RW'(a); r.s2 = RW'(b);
    return r;
  endfunction

  task automatic run_prog(input logic reordered, output int st, output int mx,
                          output int c2, output int c5);
    for (int i = 0; i < 16; i++) rom[i] = '0;
    if (!reordered) begin
      rom[0] = mk(1, 9, 8, 0);   rom[1] = mk(1, 10, 8, 0);
      rom[2] = mk(0, 11, 9, 10); rom[3] = mk(0, 0, 8, 11);
      rom[4] = mk(1, 12, 8, 0);  rom[5] = mk(0, 13, 9, 12);
      rom[6] = mk(0, 0, 8, 13);
    end else begin
      rom[0] = mk(1, 9, 8, 0);   rom[1] = mk(1, 10, 8, 0);
      rom[2] = mk(1, 12, 8, 0);  rom[3] = mk(0, 11, 9, 10);
      rom[4] = mk(0, 0, 8, 11);  rom[5] = mk(0, 13, 9, 12);
      rom[6] = mk(0, 0, 8, 13);
    end
    @(negedge clk); rst = 1'b1; pipe_mode = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    repeat (16) @(negedge clk);
    st = stalls; mx = max_run; c2 = dec2_cnt; c5 = dec5_cnt;
    pipe_mode = 1'b0;
  endtask

  task automatic t_dependent(output int st);
    int mx, c2, c5;
    run_prog(1'b0, st, mx, c2, c5);
    check(st == 2, "R8 dependent stalls", st, 2);
    check(mx == 1, "R7 single-cycle stall", mx, 1);
    check(c2 == 2, "R7 redecode of first consumer", c2, 2);
    check(c5 == 2, "R7 redecode of second consumer", c5, 2);
  endtask

  task automatic t_reordered(input int dep_st);
    int st, mx, c2, c5;
    run_prog(1'b1, st, mx, c2, c5);
    check(st == 0, "R8 reordered stalls", st, 0);
    check(dep_st - st == 2, "R8 stall difference", dep_st - st, 2);
    check(c5 == 1, "R7 no redecode without hazard", c5, 1);
  endtask

  initial begin
    int dep;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_src_a();
    t_src_b();
    t_no_read();
    t_zero_dst();
    t_idle();
    t_dependent(dep);
    t_reordered(dep);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule